// File: doc/BRIEF.md
# Two-Digit Decimal Rate Divider

This block divides a clock-rate event stream by a whole number given as two decimal digits. The tens digit and the units digit are each presented as a 4-bit BCD value. Together they select a ratio from 1 to 99. Internally there are two decade down-count stages on the same clock. The units stage steps on every active cycle. The tens stage steps only while the units stage sits at zero. When both stages read zero, the output `fout` is driven low for that one cycle. On the following edge, both stages reload from the preset.

The stages are loaded with the preset minus one, so each output period spans exactly `10*T + U` input clocks. A preset of zero stops the chain and holds `fout` high. A digit above nine is treated as nine.

The preset is sampled only on a reload edge, or on the first edge after reset or after a zero preset. A change made in the middle of a period therefore takes effect at the next period boundary. All pins are plain level signals with no handshake. `rst` is synchronous and active high.

Top module: `bcd_rate_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `fout` reads high in the following cycle.
- R2: For a legal nonzero preset with tens digit T and units digit U, successive low cycles of `fout` are exactly `10*T + U` clocks apart. The tens stage changes only on a reload or when the units stage was at zero.
- R3: For a ratio of 2 or more, `fout` is low for exactly one clock per output period.
- R4: With a ratio of 1 (T=0, U=1), `fout` stays low on every cycle after the first clock edge following reset.
- R5: With a preset of T=0 and U=0, the chain does not count and `fout` stays high.
- R6: A preset digit with a value of 10 to 15 is used as 9, so the stage registers never hold a value above 9. For example, T=12 and U=15 give a ratio of 99.
- R7: A preset change made in the middle of a period does not alter that period. The new ratio applies from the next reload.
- R8: After reset is released, the first low cycle of `fout` is the Nth cycle after release, where N = `10*T + U`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| preset_tens | input | 4 | Tens digit of the ratio, BCD |
| preset_units | input | 4 | Units digit of the ratio, BCD |
| fout | output | 1 | Divided output; low for one clock per period |

## Verification
The assertions assume that `rst` is synchronous to `clk`. They assume the preset is settled at each rising edge, and they allow it to change on any cycle. The bench applies every preset and reset change on the falling clock edge and samples `fout` on the falling edge as well, so every value is stable around the rising edge. The zero-preset idle check relies on the preset being zero before the chain is armed. The bench applies that case under reset.

// File: rtl/bcd_rate_pkg.sv
package bcd_rate_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGITS    = 2;
  localparam int DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [DIGITS-1:0][DIGIT_W-1:0] digits_t;

  function automatic digit_t clamp_digit(input digit_t d);
    return (d > digit_t'(DIGIT_MAX)) ? digit_t'(DIGIT_MAX) : d;
  endfunction
endpackage

// File: rtl/bcd_preset_prep.sv
module bcd_preset_prep
  import bcd_rate_pkg::*;
(
  input  digits_t raw,
  output digits_t reload,
  output logic    nonzero
);
  digits_t clamped;
  logic [DIGITS:0] borrow;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign clamped[i] = clamp_digit(raw[i]);
    assign reload[i]  = !borrow[i] ? clamped[i] :
                        (clamped[i] == '0) ? digit_t'(DIGIT_MAX) :
                        clamped[i] - digit_t'(1);
    assign borrow[i+1] = borrow[i] & (clamped[i] == '0);
  end

  assign nonzero = |clamped;
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  output logic [W-1:0] digit,
  output logic         at_zero
);
  always_ff @(posedge clk) begin
    if (rst)          digit <= '0;
    else if (load)    digit <= load_val;
    else if (cnt_en)  digit <= (digit == '0) ? W'(MAX) : digit - W'(1);
  end

  assign at_zero = (digit == '0);
endmodule

// File: rtl/bcd_rate_divider.sv
module bcd_rate_divider
  import bcd_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] preset_tens,
  input  logic [3:0] preset_units,
  output logic       fout
);
  digits_t         raw, reload, digit_q;
  logic            nonzero, armed_q, all_zero, load;
  logic [DIGITS-1:0] term, en;

  assign raw[0] = preset_units;
  assign raw[1] = preset_tens;

  bcd_preset_prep u_prep (
    .raw     (raw),
    .reload  (reload),
    .nonzero (nonzero)
  );

  assign all_zero = &term;
  assign load     = nonzero & (~armed_q | all_zero);

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign en[i] = armed_q & ~all_zero;
    end else begin : g_next
      assign en[i] = en[i-1] & term[i-1];
    end
    bcd_digit_stage #(.W(DIGIT_W), .MAX(DIGIT_MAX)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (reload[i]),
      .cnt_en   (en[i]),
      .digit    (digit_q[i]),
      .at_zero  (term[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                               armed_q <= 1'b0;
    else if (armed_q & all_zero & ~nonzero) armed_q <= 1'b0;
    else if (load)                         armed_q <= 1'b1;
  end

  assign fout = ~(armed_q & all_zero);

  logic [DIGIT_W-1:0] units_w, tens_w;
  logic               reload_nz;
  assign units_w   = digit_q[0];
  assign tens_w    = digit_q[1];
  assign reload_nz = |reload;
endmodule

// File: rtl/bcd_rate_divider_chk.sv
module bcd_rate_divider_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] preset_tens,
  input logic [3:0] preset_units,
  input logic       fout,
  input logic       armed,
  input logic       load,
  input logic [3:0] units,
  input logic [3:0] tens,
  input logic       reload_nz
);
  // R1
  reset_high_chk: assert property (@(posedge clk) rst |=> fout);

  // R5
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && preset_tens == 4'd0 && preset_units == 4'd0) |=> (fout && !armed));

  // R3
  single_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!fout && reload_nz) |=> fout);

  // R6
  legal_digit_chk: assert property (@(posedge clk) disable iff (rst)
    (units <= 4'd9 && tens <= 4'd9));

  // R2
  cascade_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tens) |-> ($past(units) == 4'd0 || $past(load)));
endmodule

bind bcd_rate_divider bcd_rate_divider_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .preset_tens  (preset_tens),
  .preset_units (preset_units),
  .fout         (fout),
  .armed        (armed_q),
  .load         (load),
  .units        (units_w),
  .tens         (tens_w),
  .reload_nz    (reload_nz)
);

// File: tb/sim_bcd_rate_divider.sv
`timescale 1ns/1ps
module sim_bcd_rate_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pt = 4'd0;
  logic [3:0] pu = 4'd0;
  logic       fout;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  int    exp_q[$];
  string tag_q[$];
  int    last_low;
  bit    last_valid = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_rate_divider u0 (
    .clk(clk), .rst(rst), .preset_tens(pt), .preset_units(pu), .fout(fout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures distance between low cycles and scores against the queue
  always @(negedge clk) begin
    if (rst) last_valid <= 0;
    else if (!fout) begin
      if (last_valid && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc - last_low == e, t, cyc - last_low, e);
      end
      last_low   <= cyc;
      last_valid <= 1;
    end
  end

  task automatic push_exp(input int n, input int reps, input string tag);
    for (int i = 0; i < reps; i++) begin
      exp_q.push_back(n);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q.size() > 0) begin
      check(0, tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic start(input logic [3:0] t, input logic [3:0] u);
    @(negedge clk);
    rst = 1'b1; pt = t; pu = u;
    @(negedge clk);
    @(negedge clk);
    check(fout == 1'b1, "R1", fout, 1);
    rst = 1'b0;
  endtask

  task automatic run_ratio(input logic [3:0] t, input logic [3:0] u, input int n,
                           input string tag);
    int k = 0;
    start(t, u);
    do begin
      @(negedge clk);
      k++;
    end while (fout && k < 200);
    check(k == n, "R8", k, n);
    push_exp(n, 4, tag);
    drain(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lows;
    int highs;
    // R1 reset state
    start(4'd0, 4'd9);
    rst = 1'b1;

    run_ratio(4'd0, 4'd9, 9,  "R2");
    run_ratio(4'd1, 4'd0, 10, "R2");
    run_ratio(4'd3, 4'd7, 37, "R3");
    run_ratio(4'd9, 4'd9, 99, "R2");
    run_ratio(4'd0, 4'd2, 2,  "R3");

    // R4: ratio of one keeps fout low
    run_ratio(4'd0, 4'd1, 1, "R4");
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!fout) lows++;
    end
    check(lows == 20, "R4", lows, 20);

    // R6: digits above nine clamp to nine
    run_ratio(4'd12, 4'd15, 99, "R6");
    run_ratio(4'd3,  4'd10, 39, "R6");

    // R5: zero preset holds fout high
    start(4'd0, 4'd0);
    highs = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (fout) highs++;
    end
    check(highs == 60, "R5", highs, 60);

    // R7: mid-period preset change applies at the next reload
    start(4'd3, 4'd7);
    while (fout) @(negedge clk);
    repeat (5) @(negedge clk);
    pt = 4'd1; pu = 4'd0;
    push_exp(37, 1, "R7");
    push_exp(10, 2, "R7");
    drain("R7");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule